// File: doc/BRIEF.md
# Outbound PCI Address Window Translator

This block sits between a CPU-side request path and a PCI Express host bridge. Each outbound CPU address is compared against a small set of programmable windows. When an address falls inside a window, the block reports the PCI space the access targets, the translated 64-bit PCI address, the prefetchable flag and the index of the matching window. For configuration-type windows it also reports the bus, device, function and register numbers taken from the window's attribute word. An address that falls in no window raises a decode error.

Every window holds four values: a 32-bit attribute word, a CPU base, a PCI base and a 64-bit length. Two windows come up ready to use after reset. One is an I/O aperture and the other is a one-to-one memory aperture. Any window can be rewritten through a simple write port. Results are registered, so each lookup produces its result one cycle after it is presented.

Top module: `pci_out_xlat`

## Requirements
- R1: After reset, every output is zero, and windows 0 and 1 hold their default contents (see R5 and R6). All other windows have a length of 0.
- R2: A lookup presented with `in_valid` high in one cycle produces `out_valid` high in the next cycle. A cycle with `in_valid` low produces `out_valid` low in the next cycle.
- R3: A window hits when CPU base ≤ address < CPU base + length. A window with a length of 0 never hits.
- R4: On a hit, `out_pci_addr` equals the window's PCI base plus (address − CPU base).
- R5: Default window 0 has a space code of 01 (I/O). It covers CPU addresses 0xE0010000 through 0xE001FFFF and maps them onto PCI addresses 0x0 through 0xFFFF.
- R6: Default window 1 has a space code of 10 (32-bit memory). It covers CPU addresses 0xE0020000 through 0xE101FFFF and maps each address onto the same PCI address.
- R7: When an address hits no window, the result has `out_dec_err`=1, `out_hit`=0, and zero in the address, space, prefetchable, index and configuration fields.
- R8: When more than one window matches, the window with the lowest index supplies the result.
- R9: `out_pref` carries attribute bit 30 of the winning window, and is 0 on a miss.
- R10: `out_space` carries attribute bits 25:24, where 00 is configuration, 01 is I/O, 10 is 32-bit memory and 11 is 64-bit memory. On a configuration-space hit, `out_bus`, `out_dev`, `out_func` and `out_reg` carry attribute bits 23:16, 15:11, 10:8 and 7:0. On any other result these four outputs are zero.
- R11: A write with `cfg_we`=1 updates the window selected by `cfg_idx`. The field is chosen by `cfg_sel`: 0 is the attribute (`cfg_wdata[31:0]`), 1 is the CPU base, 2 is the PCI base and 3 is the length. Lookups see the new value from the next cycle onward.
- R12: In any cycle where `out_valid` is 0, every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | CPU address to translate |
| cfg_we | input | 1 | Window write enable |
| cfg_idx | input | 2 | Window index to write |
| cfg_sel | input | 2 | Field select: 0 attribute, 1 CPU base, 2 PCI base, 3 length |
| cfg_wdata | input | 64 | Write data |
| out_valid | output | 1 | Result valid, one cycle after the lookup |
| out_hit | output | 1 | A window matched |
| out_win | output | 2 | Index of the matching window |
| out_dec_err | output | 1 | No window matched |
| out_space | output | 2 | PCI space code |
| out_pref | output | 1 | Prefetchable flag |
| out_pci_addr | output | 64 | Translated PCI address |
| out_bus | output | 8 | Configuration bus number |
| out_dev | output | 5 | Configuration device number |
| out_func | output | 3 | Configuration function number |
| out_reg | output | 8 | Configuration register number |

## Verification
Window contents are never visible directly. A corrupted base, length or attribute therefore shows up only on the first lookup that lands near that window. The symptom is a wrong translated address, a hit where a miss is expected (or the reverse), or a wrong space code. It appears on the cycle after that lookup. For this reason the bench probes both edges of every window it touches, and it re-probes a window right after each write. A fault in the priority choice shows up only while two windows overlap, so one overlap is built on purpose and then removed.

// File: rtl/pci_xlat_pkg.sv
package pci_xlat_pkg;

    typedef enum logic [1:0] {
        SP_CFG   = 2'b00,
        SP_IO    = 2'b01,
        SP_MEM32 = 2'b10,
        SP_MEM64 = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        FLD_ATTR = 2'd0,
        FLD_CPU  = 2'd1,
        FLD_PCI  = 2'd2,
        FLD_LEN  = 2'd3
    } field_e;

    typedef struct packed {
        logic [31:0] attr;
        logic [63:0] cpu_base;
        logic [63:0] pci_base;
        logic [63:0] len;
    } win_t;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [7:0] rnum;
    } cfg_tgt_t;

    localparam int ATTR_PREF_BIT = 30;

    function automatic space_e attr_space(input logic [31:0] a);
        return space_e'(a[25:24]);
    endfunction

    function automatic cfg_tgt_t attr_target(input logic [31:0] a);
        cfg_tgt_t t;
        t.bus  = a[23:16];
        t.dev  = a[15:11];
        t.func = a[10:8];
        t.rnum = a[7:0];
        return t;
    endfunction

    function automatic win_t default_win(input int idx);
        win_t w;
        w = '0;
        if (idx == 0) begin
            w.attr     = 32'h0100_0000;
            w.cpu_base = 64'h0000_0000_E001_0000;
            w.pci_base = 64'h0;
            w.len      = 64'h0000_0000_0001_0000;
        end else if (idx == 1) begin
            w.attr     = 32'h0200_0000;
            w.cpu_base = 64'h0000_0000_E002_0000;
            w.pci_base = 64'h0000_0000_E002_0000;
            w.len      = 64'h0000_0000_0100_0000;
        end
        return w;
    endfunction

endpackage

// File: rtl/xlat_win_table.sv
module xlat_win_table
    import pci_xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int CPU_AW  = 32,
    localparam int IDXW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [IDXW-1:0]         cfg_idx,
    input  logic [1:0]              cfg_sel,
    input  logic [63:0]             cfg_wdata,
    output win_t [NUM_WIN-1:0]      tbl
);
    logic [63:0] cpu_wr;
    assign cpu_wr = {{(64-CPU_AW){1'b0}}, cfg_wdata[CPU_AW-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WIN; i++) tbl[i] <= default_win(i);
        end else if (cfg_we && (int'(cfg_idx) < NUM_WIN)) begin
            case (field_e'(cfg_sel))
                FLD_ATTR: tbl[cfg_idx].attr     <= cfg_wdata[31:0];
                FLD_CPU:  tbl[cfg_idx].cpu_base <= cpu_wr;
                FLD_PCI:  tbl[cfg_idx].pci_base <= cfg_wdata;
                default:  tbl[cfg_idx].len      <= cfg_wdata;
            endcase
        end
    end

    // R11: a length write is visible in the table on the following cycle
    a_r11_len_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (int'(cfg_idx) < NUM_WIN) && cfg_sel == 2'd3)
        |=> tbl[$past(cfg_idx)].len == $past(cfg_wdata));
endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
    import pci_xlat_pkg::*;
#(
    parameter int CPU_AW = 32
) (
    input  win_t                win,
    input  logic [CPU_AW-1:0]   addr,
    output logic                hit,
    output logic [63:0]         pci_addr
);
    logic [63:0] a64;
    logic [63:0] off;
    logic        above;

    always_comb begin
        a64      = {{(64-CPU_AW){1'b0}}, addr};
        above    = (a64 >= win.cpu_base);
        off      = a64 - win.cpu_base;
        hit      = above && (off < win.len);
        pci_addr = win.pci_base + off;
    end
endmodule

// File: rtl/xlat_first_hit.sv
module xlat_first_hit #(
    parameter int NUM_WIN = 4,
    localparam int IDXW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IDXW-1:0]    idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/pci_out_xlat.sv
module pci_out_xlat
    import pci_xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int CPU_AW  = 32,
    localparam int IDXW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CPU_AW-1:0] in_addr,
    input  logic              cfg_we,
    input  logic [IDXW-1:0]   cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [63:0]       cfg_wdata,
    output logic              out_valid,
    output logic              out_hit,
    output logic [IDXW-1:0]   out_win,
    output logic              out_dec_err,
    output logic [1:0]        out_space,
    output logic              out_pref,
    output logic [63:0]       out_pci_addr,
    output logic [7:0]        out_bus,
    output logic [4:0]        out_dev,
    output logic [2:0]        out_func,
    output logic [7:0]        out_reg
);
    win_t [NUM_WIN-1:0]             tbl;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][63:0]       xl_addr;
    logic                           any_hit;
    logic [IDXW-1:0]                pick;
    logic [31:0]                    pick_attr;
    cfg_tgt_t                       tgt;

    xlat_win_table #(.NUM_WIN(NUM_WIN), .CPU_AW(CPU_AW)) u_tbl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tbl(tbl)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        xlat_win_match #(.CPU_AW(CPU_AW)) u_m (
            .win(tbl[g]), .addr(in_addr),
            .hit(hit_vec[g]), .pci_addr(xl_addr[g])
        );
    end

    xlat_first_hit #(.NUM_WIN(NUM_WIN)) u_pick (
        .hits(hit_vec), .any(any_hit), .idx(pick)
    );

    assign pick_attr = tbl[pick].attr;
    assign tgt       = attr_target(pick_attr);

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid    <= 1'b0;
            out_hit      <= 1'b0;
            out_win      <= '0;
            out_dec_err  <= 1'b0;
            out_space    <= '0;
            out_pref     <= 1'b0;
            out_pci_addr <= '0;
            {out_bus, out_dev, out_func, out_reg} <= '0;
        end else begin
            out_valid   <= 1'b1;
            out_hit     <= any_hit;
            out_dec_err <= !any_hit;
            if (any_hit) begin
                out_win      <= pick;
                out_space    <= attr_space(pick_attr);
                out_pref     <= pick_attr[ATTR_PREF_BIT];
                out_pci_addr <= xl_addr[pick];
                if (attr_space(pick_attr) == SP_CFG)
                    {out_bus, out_dev, out_func, out_reg} <= tgt;
                else
                    {out_bus, out_dev, out_func, out_reg} <= '0;
            end else begin
                out_win      <= '0;
                out_space    <= '0;
                out_pref     <= 1'b0;
                out_pci_addr <= '0;
                {out_bus, out_dev, out_func, out_reg} <= '0;
            end
        end
    end

    // R2: one-cycle latency
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7: a miss carries no translation
    a_r7_miss_clean: assert property (@(posedge clk) disable iff (rst)
        out_dec_err |-> (out_valid && !out_hit && out_pci_addr == 64'h0 && !out_pref));
    // R8: the chosen window matches and no lower window does
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (hit_vec[pick] &&
                     $countones(hit_vec & ((NUM_WIN'(1) << pick) - NUM_WIN'(1))) == 0));
    // R9: prefetchable only on a hit
    a_r9_pref_on_hit: assert property (@(posedge clk) disable iff (rst)
        out_pref |-> out_hit);
    // R10: configuration target is zero unless a configuration hit
    a_r10_cfg_only: assert property (@(posedge clk) disable iff (rst)
        (!out_hit || out_space != 2'b00) |-> {out_bus, out_dev, out_func, out_reg} == '0);
    // R12: idle outputs are zero
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_hit && !out_dec_err && out_pci_addr == 64'h0));
endmodule

// File: tb/sim_pci_out_xlat.sv
module sim_pci_out_xlat;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_addr;
    logic        cfg_we;
    logic [1:0]  cfg_idx;
    logic [1:0]  cfg_sel;
    logic [63:0] cfg_wdata;
    logic        out_valid, out_hit, out_dec_err, out_pref;
    logic [1:0]  out_win, out_space;
    logic [63:0] out_pci_addr;
    logic [7:0]  out_bus, out_reg;
    logic [4:0]  out_dev;
    logic [2:0]  out_func;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pci_out_xlat u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_dec_err(out_dec_err), .out_space(out_space), .out_pref(out_pref),
        .out_pci_addr(out_pci_addr), .out_bus(out_bus), .out_dev(out_dev),
        .out_func(out_func), .out_reg(out_reg)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [1:0]  win;
        logic [1:0]  space;
        logic [63:0] pa;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{32'hE001_0000, 1'b1, 2'd0, 2'b01, 64'h0},            // R5 low edge
        '{32'hE001_FFFF, 1'b1, 2'd0, 2'b01, 64'hFFFF},         // R5 high edge
        '{32'hE001_2345, 1'b1, 2'd0, 2'b01, 64'h2345},         // R4 offset
        '{32'hE002_0000, 1'b1, 2'd1, 2'b10, 64'hE002_0000},    // R6 low edge
        '{32'hE101_FFFF, 1'b1, 2'd1, 2'b10, 64'hE101_FFFF},    // R6 high edge
        '{32'hE102_0000, 1'b0, 2'd0, 2'b00, 64'h0},            // R3 one past end
        '{32'hE000_FFFF, 1'b0, 2'd0, 2'b00, 64'h0},            // R3 one below base
        '{32'h0000_0000, 1'b0, 2'd0, 2'b00, 64'h0}             // R7 far miss
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] idx, input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_addr = '0;
        cfg_we = 1'b0; cfg_idx = '0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1", "out_valid", 64'(out_valid), 64'h0);
        check("R1", "out_dec_err", 64'(out_dec_err), 64'h0);
        check("R1", "out_pci_addr", out_pci_addr, 64'h0);

        // table walk over default windows: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NVEC; i++) begin
            lookup(VEC[i].addr);
            check("R2", "out_valid", 64'(out_valid), 64'h1);
            check("R3", "out_hit", 64'(out_hit), 64'(VEC[i].hit));
            check("R7", "out_dec_err", 64'(out_dec_err), 64'(!VEC[i].hit));
            check("R4", "out_pci_addr", out_pci_addr, VEC[i].pa);
            check("R10", "out_space", 64'(out_space), 64'(VEC[i].space));
            check("R5", "out_win", 64'(out_win), 64'(VEC[i].win));
            check("R9", "out_pref", 64'(out_pref), 64'h0);
            check("R10", "cfg fields", 64'({out_bus, out_dev, out_func, out_reg}), 64'h0);
        end

        // R12 / R2: idle cycle returns zeros
        @(negedge clk);
        check("R2", "idle out_valid", 64'(out_valid), 64'h0);
        check("R12", "idle out_pci_addr", out_pci_addr, 64'h0);
        check("R12", "idle out_hit", 64'(out_hit), 64'h0);

        // R3: unprogrammed window 2 (length 0) never hits even with base set
        wr(2'd2, 2'd1, 64'hD000_0000);
        lookup(32'hD000_0000);
        check("R3", "zero length miss", 64'(out_dec_err), 64'h1);

        // R10 R11: configuration window, bus 1 dev 3 func 2 reg 0x10
        wr(2'd2, 2'd0, 64'h0001_1A10);
        wr(2'd2, 2'd2, 64'h100);
        wr(2'd2, 2'd3, 64'h1000);
        lookup(32'hD000_0020);
        check("R11", "cfg hit", 64'(out_hit), 64'h1);
        check("R10", "cfg space", 64'(out_space), 64'h0);
        check("R4", "cfg addr", out_pci_addr, 64'h120);
        check("R10", "bus", 64'(out_bus), 64'h1);
        check("R10", "dev", 64'(out_dev), 64'h3);
        check("R10", "func", 64'(out_func), 64'h2);
        check("R10", "reg", 64'(out_reg), 64'h10);
        check("R11", "win", 64'(out_win), 64'h2);

        // R8: window 3 overlaps window 1, lower index wins
        wr(2'd3, 2'd0, 64'hC300_0000);
        wr(2'd3, 2'd1, 64'hE003_0000);
        wr(2'd3, 2'd2, 64'h1_0000_0000);
        wr(2'd3, 2'd3, 64'h1000);
        lookup(32'hE003_0010);
        check("R8", "overlap win", 64'(out_win), 64'h1);
        check("R8", "overlap addr", out_pci_addr, 64'hE003_0010);
        check("R9", "overlap pref", 64'(out_pref), 64'h0);

        // R11: disable window 1 by zero length, window 3 now takes it
        wr(2'd1, 2'd3, 64'h0);
        lookup(32'hE003_0010);
        check("R11", "after disable win", 64'(out_win), 64'h3);
        check("R4", "64-bit addr", out_pci_addr, 64'h1_0000_0010);
        check("R10", "mem64 space", 64'(out_space), 64'h3);
        check("R9", "pref passthrough", 64'(out_pref), 64'h1);
        lookup(32'hE003_0FFF);
        check("R3", "last byte hit", 64'(out_hit), 64'h1);
        lookup(32'hE003_1000);
        check("R3", "end exclusive", 64'(out_dec_err), 64'h1);
        check("R7", "miss space", 64'(out_space), 64'h0);
        check("R7", "miss win", 64'(out_win), 64'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule